// File: doc/BRIEF.md
# Byte-Command I2C Bus Master

This block lets a processor run an I2C bus one byte at a time. Software first puts a byte in the data buffer. That byte is either a target address with a direction flag or a payload byte. Software then writes a single control word. If the word carries the transfer-byte and unit-enable bits, the block runs one byte on the bus. The same word can ask for a START before the byte, a STOP after it, and a NACK in place of the ACK when the block is receiving.

The block drives SCL and SDA as open-drain pull-low enables and reads the wired bus back through two inputs. SCL is paced by a parameterised quarter-period divider of the system clock. When a byte finishes, the block sets sticky flags in a status word. A byte acknowledged by the bus raises transmit-empty after an address or write byte, and receive-full after a read byte. A byte that is not acknowledged raises transmit-empty, bus-error and the not-acknowledged flag. The status flags, masked by enables in the control word, drive one interrupt line.

A bus monitor register gives the sampled line levels. A slave-address register is held for readback only.

Top module: `i2c_host_ctrl`

## Requirements
- R1: After reset, the control, status and data buffer registers read 0, `irq` is low, and neither bus line is pulled low. The bus monitor register (offset 0x80) reads 3.
- R2: A write to the slave-address register (0xA0) keeps bits 6:0. A write to the data buffer (0x88) keeps bits 7:0. The control register (0x90) reads back the written value with bit 3 forced to 0.
- R3: A control write that does not have both bit 3 (transfer byte) and bit 6 (unit enable) set starts no transfer. Both lines stay released and status bit 2 stays 0.
- R4: A control write with bits 0, 3 and 6 set produces a START condition and then sends the data buffer byte, with the 7-bit target address in bits 7:1. Status bit 0 then reads back data buffer bit 0 (1 means read). Status bit 2 (busy) is 1 from that write until a STOP completes.
- R5: A control write with bits 3 and 6 set and bit 0 clear, made while status bit 0 is 0, sends the data buffer MSB first. If the byte is acknowledged, status bit 6 is set and status bit 1 is cleared.
- R6: A byte sent by the block that the bus does not acknowledge sets status bits 10, 6 and 1.
- R7: A byte command with bit 0 clear, made while status bit 0 is 1, receives 8 bits MSB first into the data buffer and sets status bit 7 (not bit 6). The block answers with ACK (SDA low) unless control bit 2 is set, in which case it answers with NACK (SDA high).
- R8: Control bit 1 set in a byte command adds a STOP after that byte. The completion flags appear once the STOP is done, with busy cleared and both lines released.
- R9: A control write with bits 6 and 4 set and bit 3 clear, made while the bus is held, generates a STOP, clears busy and raises no completion flag.
- R10: Status bits 10:4 are cleared by writing 1 to them. A write of 0 to a bit leaves it unchanged. Bits 2:0 are unaffected by status writes.
- R11: `irq` is high exactly when (status[10] and control[10]) or (status[7] and control[9]) or (status[6] and control[8]) or status[9] holds.
- R12: During data and acknowledge bits, SDA changes only while SCL is low. The bus monitor reports the sampled SCL level in bit 1 and the sampled SDA level in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe for one cycle |
| reg_addr | input | 8 | Register offset from the block base |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request, active high |
| scl_i | input | 1 | Sampled SCL bus level |
| sda_i | input | 1 | Sampled SDA bus level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench runs against a behavioural target on the wired bus and sweeps a series of payload bytes, each checked bit for bit at the target. A design that shifted LSB first, or sampled before SCL rose, would show up as wrong logged bytes. It then forces a refused payload byte (0xEE) and an unmatched address, and runs a read burst whose last byte is NACKed. A block that confused receive-full with transmit-empty, dropped the bus-error flag, or ACKed the final read byte and so left the target driving SDA would miscompare there. It also writes status bits one at a time to catch a clear that wipes neighbouring flags, reads control back to catch a stored transfer bit, and issues an abort from a held bus to catch a STOP that never releases busy.

// File: rtl/i2c_host_pkg.sv
`timescale 1ns/1ps
package i2c_host_pkg;
  localparam logic [7:0] OFS_MON  = 8'h80;
  localparam logic [7:0] OFS_DATA = 8'h88;
  localparam logic [7:0] OFS_CTRL = 8'h90;
  localparam logic [7:0] OFS_STAT = 8'h98;
  localparam logic [7:0] OFS_SADR = 8'hA0;

  localparam int CB_START = 0;
  localparam int CB_STOP  = 1;
  localparam int CB_NACK  = 2;
  localparam int CB_XFER  = 3;
  localparam int CB_ABORT = 4;
  localparam int CB_UNIT  = 6;
  localparam int CB_TXIE  = 8;
  localparam int CB_RXIE  = 9;
  localparam int CB_ERRIE = 10;
  localparam logic [15:0] CTRL_KEEP = 16'hFFF7;

  // sticky status flags live in bits 10:4; index below is relative to bit 4
  localparam int STICKY_LO = 4;
  localparam int STICKY_W  = 7;
  localparam int SF_TXE = 6 - STICKY_LO;
  localparam int SF_RXF = 7 - STICKY_LO;
  localparam int SF_ADR = 9 - STICKY_LO;
  localparam int SF_ERR = 10 - STICKY_LO;

  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_BITS, PH_STOP} phase_t;

  typedef struct packed {
    logic       go_start;
    logic       go_stop;
    logic       rd;
    logic       nack;
    logic [7:0] byte_out;
  } xfer_cmd_t;
endpackage

// File: rtl/i2c_tick_gen.sv
`timescale 1ns/1ps
module i2c_tick_gen #(
  parameter int unsigned QTR = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = (QTR > 1) ? $clog2(QTR) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR - 1);

  logic [CW-1:0] cnt_q, cnt_n;

  assign tick = en && (cnt_q == LAST);

  always_comb begin
    cnt_n = cnt_q;
    if (!en || tick) cnt_n = '0;
    else             cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/i2c_bit_engine.sv
`timescale 1ns/1ps
module i2c_bit_engine
  import i2c_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       launch,
  input  logic       abort,
  input  xfer_cmd_t  cmd,
  input  logic       sda_in,
  output logic       scl_low,
  output logic       sda_low,
  output logic       busy,
  output logic       done,
  output logic       nacked,
  output logic       rd_byte,
  output logic       released,
  output logic [7:0] rx_byte,
  output phase_t     phase
);
  phase_t    ph_q, ph_n;
  logic [1:0] qc_q, qc_n;
  logic [3:0] bn_q, bn_n;
  logic [7:0] sh_q, sh_n;
  xfer_cmd_t cmd_q, cmd_n;
  logic scl_q, scl_n, sda_q, sda_n, nak_q, nak_n, abrt_q, abrt_n;
  logic done_q, done_n, rel_q, rel_n;
  logic last_bit;

  assign last_bit = (bn_q == 4'd8);

  // quarter 0: set SDA, 1: release SCL, 2: sample, 3: pull SCL low
  always_comb begin
    ph_n = ph_q; qc_n = qc_q; bn_n = bn_q; sh_n = sh_q; cmd_n = cmd_q;
    scl_n = scl_q; sda_n = sda_q; nak_n = nak_q; abrt_n = abrt_q;
    done_n = 1'b0; rel_n = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (launch) begin
          cmd_n = cmd; sh_n = cmd.byte_out; nak_n = 1'b0; abrt_n = 1'b0;
          qc_n = 2'd0; bn_n = 4'd0;
          ph_n = cmd.go_start ? PH_START : PH_BITS;
        end else if (abort) begin
          abrt_n = 1'b1; qc_n = 2'd0; ph_n = PH_STOP;
        end
      end
      PH_START: if (tick) begin
        qc_n = qc_q + 2'd1;
        unique case (qc_q)
          2'd0: sda_n = 1'b0;
          2'd1: scl_n = 1'b0;
          2'd2: sda_n = 1'b1;
          default: begin scl_n = 1'b1; ph_n = PH_BITS; end
        endcase
      end
      PH_BITS: if (tick) begin
        qc_n = qc_q + 2'd1;
        unique case (qc_q)
          2'd0: sda_n = last_bit ? (cmd_q.rd & ~cmd_q.nack) : (~cmd_q.rd & ~sh_q[7]);
          2'd1: scl_n = 1'b0;
          2'd2: begin
            if (last_bit) nak_n = ~cmd_q.rd & sda_in;
            else          sh_n  = {sh_q[6:0], sda_in};
          end
          default: begin
            scl_n = 1'b1;
            if (last_bit) begin
              bn_n = 4'd0;
              if (cmd_q.go_stop) ph_n = PH_STOP;
              else begin ph_n = PH_IDLE; done_n = 1'b1; end
            end else begin
              bn_n = bn_q + 4'd1;
            end
          end
        endcase
      end
      default: if (tick) begin
        qc_n = qc_q + 2'd1;
        unique case (qc_q)
          2'd0: sda_n = 1'b1;
          2'd1: scl_n = 1'b0;
          2'd2: sda_n = 1'b0;
          default: begin ph_n = PH_IDLE; rel_n = 1'b1; done_n = ~abrt_q; end
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE; qc_q <= '0; bn_q <= '0; sh_q <= '0; cmd_q <= '0;
      scl_q <= 1'b0; sda_q <= 1'b0; nak_q <= 1'b0; abrt_q <= 1'b0;
      done_q <= 1'b0; rel_q <= 1'b0;
    end else begin
      ph_q <= ph_n; qc_q <= qc_n; bn_q <= bn_n; sh_q <= sh_n; cmd_q <= cmd_n;
      scl_q <= scl_n; sda_q <= sda_n; nak_q <= nak_n; abrt_q <= abrt_n;
      done_q <= done_n; rel_q <= rel_n;
    end
  end

  assign scl_low  = scl_q;
  assign sda_low  = sda_q;
  assign busy     = (ph_q != PH_IDLE);
  assign done     = done_q;
  assign nacked   = nak_q;
  assign rd_byte  = cmd_q.rd;
  assign released = rel_q;
  assign rx_byte  = sh_q;
  assign phase    = ph_q;
endmodule

// File: rtl/i2c_host_ctrl.sv
`timescale 1ns/1ps
module i2c_host_ctrl
  import i2c_host_pkg::*;
#(
  parameter int unsigned QTR_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        scl_oe,
  output logic        sda_oe
);
  logic [15:0] ctrl_q, ctrl_n;
  logic [STICKY_W-1:0] sts_q, sts_n;
  logic rwm_q, rwm_n, acknak_q, acknak_n, own_q, own_n;
  logic [7:0] dbuf_q, dbuf_n;
  logic [6:0] sar_q, sar_n;
  logic [1:0] mon_q;

  logic tick, eng_busy, eng_done, eng_nak, eng_rd, eng_rel, busy_flag;
  logic [7:0] eng_rx;
  phase_t eng_phase;
  logic ctrl_wr, launch, abort;
  xfer_cmd_t cmd;

  assign ctrl_wr = reg_wr && (reg_addr == OFS_CTRL);
  assign launch  = ctrl_wr && reg_wdata[CB_XFER] && reg_wdata[CB_UNIT] && !eng_busy;
  assign abort   = ctrl_wr && !reg_wdata[CB_XFER] && reg_wdata[CB_UNIT] &&
                   reg_wdata[CB_ABORT] && own_q && !eng_busy;

  assign cmd.go_start = reg_wdata[CB_START];
  assign cmd.go_stop  = reg_wdata[CB_STOP];
  assign cmd.nack     = reg_wdata[CB_NACK];
  assign cmd.rd       = !reg_wdata[CB_START] && rwm_q;
  assign cmd.byte_out = dbuf_q;

  i2c_tick_gen #(.QTR(QTR_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(eng_busy), .tick(tick)
  );

  i2c_bit_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .launch(launch), .abort(abort),
    .cmd(cmd), .sda_in(mon_q[0]), .scl_low(scl_oe), .sda_low(sda_oe),
    .busy(eng_busy), .done(eng_done), .nacked(eng_nak), .rd_byte(eng_rd),
    .released(eng_rel), .rx_byte(eng_rx), .phase(eng_phase)
  );

  always_comb begin
    ctrl_n = ctrl_q; sts_n = sts_q; rwm_n = rwm_q; acknak_n = acknak_q;
    own_n = own_q; dbuf_n = dbuf_q; sar_n = sar_q;
    if (eng_rel) own_n = 1'b0;
    if (reg_wr) begin
      unique case (reg_addr)
        OFS_CTRL: begin
          ctrl_n = reg_wdata & CTRL_KEEP;
          if (launch && reg_wdata[CB_START]) begin
            rwm_n = dbuf_q[0];
            own_n = 1'b1;
          end
        end
        OFS_STAT: sts_n = sts_q & ~reg_wdata[STICKY_LO +: STICKY_W];
        OFS_DATA: dbuf_n = reg_wdata[7:0];
        OFS_SADR: sar_n = reg_wdata[6:0];
        default: ;
      endcase
    end
    if (eng_done) begin
      if (eng_nak) begin
        sts_n[SF_TXE] = 1'b1; sts_n[SF_ERR] = 1'b1; acknak_n = 1'b1;
      end else begin
        acknak_n = 1'b0;
        if (eng_rd) begin sts_n[SF_RXF] = 1'b1; dbuf_n = eng_rx; end
        else              sts_n[SF_TXE] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; sts_q <= '0; rwm_q <= 1'b0; acknak_q <= 1'b0;
      own_q <= 1'b0; dbuf_q <= '0; sar_q <= '0; mon_q <= 2'b11;
    end else begin
      ctrl_q <= ctrl_n; sts_q <= sts_n; rwm_q <= rwm_n; acknak_q <= acknak_n;
      own_q <= own_n; dbuf_q <= dbuf_n; sar_q <= sar_n; mon_q <= {scl_i, sda_i};
    end
  end

  assign busy_flag = own_q | eng_busy;

  always_comb begin
    unique case (reg_addr)
      OFS_MON:  reg_rdata = {14'd0, mon_q};
      OFS_DATA: reg_rdata = {8'd0, dbuf_q};
      OFS_CTRL: reg_rdata = ctrl_q;
      OFS_STAT: reg_rdata = {5'd0, sts_q, 1'b0, busy_flag, acknak_q, rwm_q};
      OFS_SADR: reg_rdata = {9'd0, sar_q};
      default:  reg_rdata = 16'd0;
    endcase
  end

  assign irq = (sts_q[SF_ERR] & ctrl_q[CB_ERRIE]) | (sts_q[SF_RXF] & ctrl_q[CB_RXIE]) |
               (sts_q[SF_TXE] & ctrl_q[CB_TXIE]) | sts_q[SF_ADR];
endmodule

// File: rtl/i2c_host_chk.sv
`timescale 1ns/1ps
module i2c_host_chk
  import i2c_host_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [7:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic        scl_oe,
  input logic        sda_oe,
  input logic [1:0]  phase,
  input logic        eng_busy,
  input logic        eng_done,
  input logic        busy_flag,
  input logic [6:0]  sticky,
  input logic [7:0]  dbuf
);
  // R12: inside data/ack bits SDA moves only with SCL held low
  a_r12_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BITS && $past(phase) == PH_BITS && sda_oe != $past(sda_oe))
      |-> (scl_oe && $past(scl_oe)));

  // R4: a START byte command marks the unit busy on the next cycle
  a_r4_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_CTRL && reg_wdata[CB_START] && reg_wdata[CB_XFER] &&
     reg_wdata[CB_UNIT] && !eng_busy) |=> busy_flag);

  // R3: no unit enable, no bus activity
  a_r3_no_launch_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_CTRL && !reg_wdata[CB_UNIT] && !eng_busy) |=> !eng_busy);

  // R10: writing one to transmit-empty clears it when no completion collides
  a_r10_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_STAT && reg_wdata[6] && !eng_done) |=> !sticky[SF_TXE]);

  // R2: data buffer keeps the low byte of a write
  a_r2_data_keeps_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_DATA && !eng_done) |=> (dbuf == $past(reg_wdata[7:0])));
endmodule

bind i2c_host_ctrl i2c_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .scl_oe(scl_oe), .sda_oe(sda_oe), .phase(eng_phase),
  .eng_busy(eng_busy), .eng_done(eng_done), .busy_flag(busy_flag),
  .sticky(sts_q), .dbuf(dbuf_q)
);

// File: tb/sim_i2c_host_ctrl.sv
`timescale 1ns/1ps
module sim_i2c_host_ctrl;
  localparam logic [7:0] A_MON = 8'h80, A_DATA = 8'h88, A_CTRL = 8'h90,
                         A_STAT = 8'h98, A_SADR = 8'hA0;
  localparam logic [6:0] SLV = 7'h2A;

  logic clk, rst_n, reg_wr, irq, scl_oe, sda_oe;
  logic [7:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic scl_bus, sda_bus, s_drv;
  int n_chk, n_bad;
  bit finished;

  assign scl_bus = !scl_oe;
  assign sda_bus = !(sda_oe | s_drv);

  i2c_host_ctrl #(.QTR_CYCLES(4)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_i(scl_bus), .sda_i(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural bus target
  int s_mode, s_cnt, rd_idx, wcnt;
  logic [7:0] s_sh, s_tx;
  logic s_mnack;
  logic [7:0] wlog [16];

  function automatic logic [7:0] rd_pat(int i);
    return 8'h5A + 8'(i * 29);
  endfunction

  initial begin
    s_drv = 1'b0; s_mode = 0; s_cnt = 0; rd_idx = 0; wcnt = 0;
    s_sh = '0; s_tx = '0; s_mnack = 1'b0;
  end

  always @(negedge sda_bus) if (scl_bus) begin s_mode = 1; s_cnt = -1; s_drv = 1'b0; end
  always @(posedge sda_bus) if (scl_bus) begin s_mode = 0; s_drv = 1'b0; end
  always @(posedge scl_bus) begin
    if ((s_mode == 1 || s_mode == 2) && s_cnt >= 0 && s_cnt < 8) s_sh = {s_sh[6:0], sda_bus};
    if (s_mode == 3 && s_cnt == 8) s_mnack = sda_bus;
  end
  always @(negedge scl_bus) if (s_mode != 0) begin
    if (s_cnt == 7) begin
      if (s_mode == 1) s_drv = (s_sh[7:1] == SLV);
      else if (s_mode == 2) begin wlog[wcnt % 16] = s_sh; wcnt++; s_drv = (s_sh != 8'hEE); end
      else s_drv = 1'b0;
      s_cnt = 8;
    end else if (s_cnt == 8) begin
      s_cnt = 0;
      if (s_mode == 1) s_mode = !s_drv ? 0 : (s_sh[0] ? 3 : 2);
      else if (s_mode == 2 && !s_drv) s_mode = 0;
      else if (s_mode == 3 && s_mnack) s_mode = 0;
      if (s_mode == 3) begin s_tx = rd_pat(rd_idx); rd_idx++; s_drv = !s_tx[7]; end
      else s_drv = 1'b0;
    end else begin
      s_cnt++;
      if (s_mode == 3) s_drv = !s_tx[7 - s_cnt];
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %04h expected %04h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic wait_flag(int bitno, string req);
    logic [15:0] v;
    for (int k = 0; k < 4000; k++) begin
      rd(A_STAT, v);
      if (v[bitno]) return;
    end
    chk(req, 16'h0, 16'h1);
  endtask

  task automatic wait_idle(string req);
    logic [15:0] v;
    for (int k = 0; k < 4000; k++) begin
      rd(A_STAT, v);
      if (!v[2]) return;
    end
    chk(req, 16'h1, 16'h0);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic seen;
    n_chk = 0; n_bad = 0; finished = 0;
    reg_wr = 1'b0; reg_addr = A_CTRL; reg_wdata = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 16'h0);
    rd(A_STAT, v); chk("R1 status", v, 16'h0);
    rd(A_DATA, v); chk("R1 data", v, 16'h0);
    rd(A_MON, v);  chk("R1 monitor", v, 16'h3);
    chk("R1 irq/lines", {13'd0, irq, scl_oe, sda_oe}, 16'h0);

    // R2 register widths
    wr(A_SADR, 16'hFFFF); rd(A_SADR, v); chk("R2 slave addr", v, 16'h007F);
    wr(A_DATA, 16'hABCD); rd(A_DATA, v); chk("R2 data", v, 16'h00CD);
    wr(A_CTRL, 16'h0F8F); rd(A_CTRL, v); chk("R2 ctrl bit3", v, 16'h0F87);

    // R3 transfer bit without unit enable
    seen = 1'b0;
    for (int k = 0; k < 60; k++) begin @(negedge clk); if (scl_oe || sda_oe) seen = 1'b1; end
    chk("R3 lines idle", {15'd0, seen}, 16'h0);
    rd(A_STAT, v); chk("R3 not busy", v & 16'h0004, 16'h0);
    wr(A_CTRL, 16'h0000);

    // R4 address phase, write direction
    wr(A_DATA, {8'd0, SLV, 1'b0});
    wr(A_CTRL, 16'h0149);
    wait_flag(6, "R4 address done");
    rd(A_STAT, v); chk("R4 status after address", v, 16'h0044);
    chk("R11 irq tx enabled", {15'd0, irq}, 16'h1);
    rd(A_MON, v);  chk("R12 monitor scl held", v, 16'h1);
    wr(A_STAT, 16'h0040);
    chk("R11 irq cleared", {15'd0, irq}, 16'h0);

    // R5 sweep of payload bytes, last one with STOP (R8)
    for (int i = 0; i < 10; i++) begin
      logic [7:0] b;
      b = 8'(i * 23 + 1);
      wr(A_DATA, {8'd0, b});
      wr(A_CTRL, (i == 9) ? 16'h014A : 16'h0148);
      wait_flag(6, "R5 byte done");
      chk("R5 byte on bus", {8'd0, wlog[i % 16]}, {8'd0, b});
      rd(A_STAT, v); chk("R5 ack flag", v & 16'h00C2, 16'h0040);
      wr(A_STAT, 16'h0040);
    end
    rd(A_STAT, v); chk("R8 busy clear after stop", v & 16'h0004, 16'h0);
    rd(A_MON, v);  chk("R8 lines released", v, 16'h3);

    // R6 refused payload byte
    wr(A_DATA, {8'd0, SLV, 1'b0}); wr(A_CTRL, 16'h0449);
    wait_flag(6, "R6 address done"); wr(A_STAT, 16'h0040);
    wr(A_DATA, 16'h00EE); wr(A_CTRL, 16'h0448);
    wait_flag(6, "R6 byte done");
    rd(A_STAT, v); chk("R6 nack flags", v, 16'h0446);
    chk("R11 irq bus error", {15'd0, irq}, 16'h1);

    // R10 write-one-to-clear behaviour
    wr(A_STAT, 16'h0000); rd(A_STAT, v); chk("R10 zero write", v, 16'h0446);
    wr(A_STAT, 16'h0040); rd(A_STAT, v); chk("R10 clear tx only", v, 16'h0406);
    wr(A_STAT, 16'h0400); rd(A_STAT, v); chk("R10 clear error", v, 16'h0006);

    // R9 abort from a held bus
    wr(A_CTRL, 16'h0050);
    wait_idle("R9 abort completes");
    rd(A_STAT, v); chk("R9 no flags", v & 16'h07F4, 16'h0);
    rd(A_MON, v);  chk("R9 lines released", v, 16'h3);
    chk("R9 target saw stop", 16'(s_mode), 16'h0);

    // R6 unmatched address with STOP
    wr(A_DATA, 16'h0022); wr(A_CTRL, 16'h014B);
    wait_flag(6, "R6 address nack done");
    rd(A_STAT, v); chk("R6 address nack", v, 16'h0442);
    wr(A_STAT, 16'h07F0);

    // R7 read burst, last byte NACKed with STOP
    wr(A_DATA, {8'd0, SLV, 1'b1}); wr(A_CTRL, 16'h0249);
    wait_flag(6, "R7 read address");
    rd(A_STAT, v); chk("R4 read direction", v & 16'h0007, 16'h0005);
    wr(A_STAT, 16'h0040);
    for (int i = 0; i < 6; i++) begin
      wr(A_CTRL, (i == 5) ? 16'h024E : 16'h0248);
      wait_flag(7, "R7 byte done");
      rd(A_DATA, v); chk("R7 received byte", v, {8'd0, rd_pat(i)});
      rd(A_STAT, v); chk("R7 rx flag only", v & 16'h00C0, 16'h0080);
      chk("R11 irq rx", {15'd0, irq}, 16'h1);
      chk("R7 master ack bit", {15'd0, s_mnack}, (i == 5) ? 16'h1 : 16'h0);
      wr(A_STAT, 16'h0080);
    end
    rd(A_STAT, v); chk("R8 read stop", v & 16'h0004, 16'h0);
    rd(A_MON, v);  chk("R12 monitor idle", v, 16'h3);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule